// File: doc/BRIEF.md
# Outer-Product Multiply-Accumulate Array

This block is the arithmetic core of a matrix coprocessor working on signed 16-bit integers. It holds two operand pools, X and Y, of eight rows each. Every row is 64 bytes wide, so it carries 32 lanes. Beside the pools sits a 64-row accumulator Z, with 32 lanes of 16 bits in each row. A 64-bit command picks one X row and one Y row and runs one of two updates. The matrix update adds the full 32x32 outer product into the even Z rows, writing one row per clock. The vector update accumulates the lane-by-lane product into a single Z row named by the command. The product may be shifted right before it is accumulated. It may also be subtracted instead of added, or it may replace Z outright. Either operand may be forced to one, and writemasks limit the lanes and rows that change.

The unit has a life cycle. A setup command brings it up with every register zeroed. A clear command takes it down again. Anything asked of a unit that is down is refused and flagged.

Commands and register writes arrive on valid/ready ports. A command is taken on a clock where `cmd_valid` and `cmd_ready` are both high. While an update is in flight, `cmd_ready` stays low, and a command held at the port must keep its word stable until it is taken. A register write is taken on a clock where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while an update runs and also in any cycle where `cmd_valid` is high, so a command always wins over a write. Contents are read back on a combinational port.

Top module: `opa_array`

## Requirements
- R1: After reset the unit is down. A setup command brings it up and zeroes all of X, Y and Z. A setup taken while the unit is up pulses `bad_cmd` for one cycle and changes nothing. The command layout is: op code in bits 62:61, where 0 is multiply-accumulate, 1 is setup, 2 is clear and 3 is reserved. A reserved op code also pulses `bad_cmd`.
- R2: A clear command takes the unit down. While it is down, readback returns zero, and every multiply-accumulate command and every register write is dropped with a `bad_cmd` pulse.
- R3: A register write loads the whole 512-bit `wr_data` into the entry chosen by the pool code and `wr_addr`. Pool code 0 selects X (address bits 2:0), 1 selects Y (address bits 2:0), 2 selects Z (all six bits), and 3 discards the write. `wr_ready` equals not busy and not `cmd_valid`.
- R4: With bit 63 clear the update is a matrix update. Over 32 busy cycles, Z row 2j lane i takes f(x[i], y[j]) for every j. `cmd_ready` is low for exactly those 32 cycles. The X row is selected by bits 52:50 and the Y row by bits 49:47.
- R5: With bit 63 set the update is a vector update. Z row r lane i takes f(x[i], y[i]), where r is bits 46:41, and the unit is busy for one cycle.
- R6: Bit 60 set subtracts the product from Z instead of adding it.
- R7: Bit 57 set writes the product into Z, or its negation when bit 60 is also set, without using the old Z value.
- R8: Bit 59 set treats every X lane as 1, and bit 58 set treats every Y lane as 1.
- R9: The full 32-bit signed product is shifted right arithmetically by bits 56:53. It is then cut to its low 16 bits and accumulated modulo 2^16.
- R10: Each 7-bit mask has a mode in bits 6:5 and a count n in bits 4:0. Mode 0 enables all lanes, 1 enables lane n only, 2 enables lanes below n, and 3 enables the top n lanes. The X mask sits in bits 40:34 and gates lanes. The Y mask sits in bits 33:27 and gates the j rows in matrix mode only.
- R11: A Z element whose lane or row is masked off keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (unit idle) |
| cmd_word | input | 64 | Command word |
| wr_valid | input | 1 | Register write offered |
| wr_ready | output | 1 | Register write can be taken |
| wr_pool | input | 2 | Write target pool: 0 X, 1 Y, 2 Z |
| wr_addr | input | 6 | Write target row |
| wr_data | input | 512 | Write data, lane i in bits 16i+15:16i |
| rd_pool | input | 2 | Readback pool |
| rd_addr | input | 6 | Readback row |
| rd_data | output | 512 | Readback data, zero while down |
| unit_live | output | 1 | Unit is set up |
| bad_cmd | output | 1 | One-cycle pulse for a refused request |

## Verification
The bench uses operands with mixed signs and large magnitudes, so a product that is shifted logically or cut before the shift would change the low 16 bits in Z. It places the matrix rows on even Z rows next to a preloaded odd row. A design that used the wrong row stride, or that took Y by lane instead of by j, would then corrupt a row that should be untouched. The bench combines boundary mask counts (n = 0, the top lane, last-n) with a Y mask. A decoder off by one would change one extra or one missing lane, and a design that ignored the Y mask in matrix mode would update whole rows. Repeated setup, the reserved op, and traffic after clear must each leave all three pools unchanged, since a design that acted on them would overwrite data.

// File: rtl/opa_pkg.sv
package opa_pkg;
  parameter int OPA_REG_W  = 3;
  parameter int OPA_ZR_W   = 6;
  parameter int OPA_SH_W   = 4;
  parameter int OPA_MASK_W = 7;

  typedef enum logic [1:0] {
    OP_MAC   = 2'd0,
    OP_SETUP = 2'd1,
    OP_CLEAR = 2'd2,
    OP_RSVD  = 2'd3
  } opa_op_e;

  localparam logic [1:0] POOL_X = 2'd0;
  localparam logic [1:0] POOL_Y = 2'd1;
  localparam logic [1:0] POOL_Z = 2'd2;

  typedef struct packed {
    logic                  vec;
    opa_op_e               op;
    logic                  sub;
    logic                  xoff;
    logic                  yoff;
    logic                  zoff;
    logic [OPA_SH_W-1:0]   shamt;
    logic [OPA_REG_W-1:0]  xsel;
    logic [OPA_REG_W-1:0]  ysel;
    logic [OPA_ZR_W-1:0]   zrow;
    logic [OPA_MASK_W-1:0] xmask;
    logic [OPA_MASK_W-1:0] ymask;
    logic [26:0]           spare;
  } opa_cmd_t;

  typedef struct packed {
    logic                sub;
    logic                xoff;
    logic                yoff;
    logic                zoff;
    logic [OPA_SH_W-1:0] shamt;
  } opa_arith_t;
endpackage

// File: rtl/opa_mask_dec.sv
module opa_mask_dec
  import opa_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [OPA_MASK_W-1:0] code_i,
  output logic [LANES-1:0]      on_o
);
  localparam int CNT_W = OPA_MASK_W - 2;

  logic [1:0]       mode;
  logic [CNT_W-1:0] cnt;

  assign mode = code_i[OPA_MASK_W-1 -: 2];
  assign cnt  = code_i[CNT_W-1:0];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      unique case (mode)
        2'd0:    on_o[i] = 1'b1;
        2'd1:    on_o[i] = (i == int'(cnt));
        2'd2:    on_o[i] = (i < int'(cnt));
        default: on_o[i] = (i >= LANES - int'(cnt));
      endcase
    end
  end

  // R10: single-lane mode never enables more than one lane
  always_comb begin
    if (mode == 2'd1) begin
      p_single_lane_r10: assert ($onehot0(on_o));
    end
  end
endmodule

// File: rtl/opa_lane_mac.sv
module opa_lane_mac
  import opa_pkg::*;
#(
  parameter int EW = 16
) (
  input  logic [EW-1:0] x_i,
  input  logic [EW-1:0] y_i,
  input  logic [EW-1:0] z_i,
  input  logic          en_i,
  input  opa_arith_t    cfg_i,
  output logic [EW-1:0] z_o
);
  localparam int PW = 2 * EW;

  logic signed [EW-1:0] xa, ya;
  logic signed [PW-1:0] prod, shifted;
  logic        [EW-1:0] term, base, acc;

  assign xa      = cfg_i.xoff ? EW'(1) : x_i;
  assign ya      = cfg_i.yoff ? EW'(1) : y_i;
  assign prod    = xa * ya;
  assign shifted = prod >>> cfg_i.shamt;
  assign term    = shifted[EW-1:0];
  assign base    = cfg_i.zoff ? '0 : z_i;
  assign acc     = cfg_i.sub ? (base - term) : (base + term);
  assign z_o     = en_i ? acc : z_i;
endmodule

// File: rtl/opa_ctrl.sv
module opa_ctrl
  import opa_pkg::*;
#(
  parameter  int LANES  = 32,
  localparam int STEP_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  opa_cmd_t          cmd_i,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic              live_o,
  output logic              bad_o,
  output logic              busy_o,
  output logic [STEP_W-1:0] step_o,
  output opa_cmd_t          cur_o,
  output logic              setup_fire_o,
  output logic              write_fire_o
);
  logic cmd_fire, wr_fire, last_step;

  assign cmd_ready    = !busy_o;
  assign wr_ready     = !busy_o && !cmd_valid;
  assign cmd_fire     = cmd_valid && cmd_ready;
  assign wr_fire      = wr_valid && wr_ready;
  assign setup_fire_o = cmd_fire && (cmd_i.op == OP_SETUP) && !live_o;
  assign write_fire_o = wr_fire && live_o;
  assign last_step    = cur_o.vec || (step_o == STEP_W'(LANES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_o <= 1'b0;
      bad_o  <= 1'b0;
      busy_o <= 1'b0;
      step_o <= '0;
      cur_o  <= '0;
    end else begin
      bad_o <= 1'b0;
      if (busy_o) begin
        if (last_step) begin
          busy_o <= 1'b0;
          step_o <= '0;
        end else begin
          step_o <= step_o + 1'b1;
        end
      end
      if (cmd_fire) begin
        unique case (cmd_i.op)
          OP_SETUP: begin
            if (live_o) bad_o <= 1'b1;
            else        live_o <= 1'b1;
          end
          OP_CLEAR: live_o <= 1'b0;
          OP_MAC: begin
            if (live_o) begin
              busy_o <= 1'b1;
              step_o <= '0;
              cur_o  <= cmd_i;
            end else begin
              bad_o <= 1'b1;
            end
          end
          default: bad_o <= 1'b1;
        endcase
      end
      if (wr_fire && !live_o) bad_o <= 1'b1;
    end
  end

  // Busy-run length counter used by the matrix-length check
  logic [STEP_W:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  run_len <= '0;
    else if (cmd_fire && cmd_i.op == OP_MAC)     run_len <= '0;
    else if (busy_o)                             run_len <= run_len + 1'b1;
  end

  p_busy_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!cmd_ready && !wr_ready));

  p_resetup_refused_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_i.op == OP_SETUP && live_o) |=> (bad_o && live_o));

  p_dead_mac_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_i.op == OP_MAC && !live_o) |=> (bad_o && !busy_o));

  p_clear_downs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_i.op == OP_CLEAR) |=> !live_o);

  p_vec_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_i.op == OP_MAC && live_o && cmd_i.vec) |=> busy_o ##1 !busy_o);

  p_mat_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && !cur_o.vec) |-> (run_len == (STEP_W+1)'(LANES)));
endmodule

// File: rtl/opa_array.sv
module opa_array
  import opa_pkg::*;
#(
  parameter int LANES = 32,
  parameter int EW    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [63:0]          cmd_word,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [1:0]           wr_pool,
  input  logic [OPA_ZR_W-1:0]  wr_addr,
  input  logic [LANES*EW-1:0]  wr_data,
  input  logic [1:0]           rd_pool,
  input  logic [OPA_ZR_W-1:0]  rd_addr,
  output logic [LANES*EW-1:0]  rd_data,
  output logic                 unit_live,
  output logic                 bad_cmd
);
  localparam int ROW_W  = LANES * EW;
  localparam int NREG   = 1 << OPA_REG_W;
  localparam int ZROWS  = 1 << OPA_ZR_W;
  localparam int STEP_W = $clog2(LANES);

  logic [ROW_W-1:0] xpool [NREG];
  logic [ROW_W-1:0] ypool [NREG];
  logic [ROW_W-1:0] zmem  [ZROWS];

  opa_cmd_t          cmd_in, cur;
  logic              live, busy, setup_fire, write_fire;
  logic [STEP_W-1:0] step;

  assign cmd_in = opa_cmd_t'(cmd_word);

  opa_ctrl #(.LANES(LANES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_i        (cmd_in),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .live_o       (live),
    .bad_o        (bad_cmd),
    .busy_o       (busy),
    .step_o       (step),
    .cur_o        (cur),
    .setup_fire_o (setup_fire),
    .write_fire_o (write_fire)
  );

  assign unit_live = live;

  // Lane and row enables from the two writemasks
  logic [LANES-1:0] xon, yon, lane_en;

  opa_mask_dec #(.LANES(LANES)) u_xmask (.code_i(cur.xmask), .on_o(xon));
  opa_mask_dec #(.LANES(LANES)) u_ymask (.code_i(cur.ymask), .on_o(yon));

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_en[i] = cur.vec ? xon[i] : (xon[i] && yon[step]);
    end
  end

  // Operand rows and target row for the current step
  logic [ROW_W-1:0]    x_row, y_row, z_old, z_new;
  logic [EW-1:0]       y_bcast;
  logic [OPA_ZR_W-1:0] zidx;
  opa_arith_t          arith;

  assign x_row   = xpool[cur.xsel];
  assign y_row   = ypool[cur.ysel];
  assign y_bcast = y_row[int'(step)*EW +: EW];
  assign zidx    = cur.vec ? cur.zrow : OPA_ZR_W'({step, 1'b0});
  assign z_old   = zmem[zidx];
  assign arith   = '{sub: cur.sub, xoff: cur.xoff, yoff: cur.yoff,
                     zoff: cur.zoff, shamt: cur.shamt};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [EW-1:0] y_op;
    assign y_op = cur.vec ? y_row[g*EW +: EW] : y_bcast;

    opa_lane_mac #(.EW(EW)) u_mac (
      .x_i   (x_row[g*EW +: EW]),
      .y_i   (y_op),
      .z_i   (z_old[g*EW +: EW]),
      .en_i  (lane_en[g]),
      .cfg_i (arith),
      .z_o   (z_new[g*EW +: EW])
    );
  end

  // Storage: setup clears, steps update Z, the write port loads rows
  always_ff @(posedge clk) begin
    if (setup_fire) begin
      for (int r = 0; r < NREG; r++) begin
        xpool[r] <= '0;
        ypool[r] <= '0;
      end
      for (int r = 0; r < ZROWS; r++) begin
        zmem[r] <= '0;
      end
    end else begin
      if (busy) zmem[zidx] <= z_new;
      if (write_fire) begin
        unique case (wr_pool)
          POOL_X:  xpool[wr_addr[OPA_REG_W-1:0]] <= wr_data;
          POOL_Y:  ypool[wr_addr[OPA_REG_W-1:0]] <= wr_data;
          POOL_Z:  zmem[wr_addr] <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // Readback
  always_comb begin
    rd_data = '0;
    if (live) begin
      unique case (rd_pool)
        POOL_X:  rd_data = xpool[rd_addr[OPA_REG_W-1:0]];
        POOL_Y:  rd_data = ypool[rd_addr[OPA_REG_W-1:0]];
        POOL_Z:  rd_data = zmem[rd_addr];
        default: rd_data = '0;
      endcase
    end
  end

  // R11: with no lane enabled the row leaving the lane array equals the row read
  p_masked_row_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lane_en == '0) |-> (z_new == z_old));

  // R2: a unit that is down never runs an update
  p_no_step_when_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> live);

  // R4: matrix steps only touch even rows
  p_even_rows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cur.vec) |-> !zidx[0]);
endmodule

// File: tb/sim_opa_array.sv
module sim_opa_array;
  localparam int L  = 32;
  localparam int W  = 16;
  localparam int RW = L * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [63:0]   cmd_word = '0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [1:0]    wr_pool = '0;
  logic [5:0]    wr_addr = '0;
  logic [RW-1:0] wr_data = '0;
  logic [1:0]    rd_pool = '0;
  logic [5:0]    rd_addr = '0;
  logic [RW-1:0] rd_data;
  logic          unit_live, bad_cmd;

  always #4 clk = ~clk;

  opa_array u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_pool(wr_pool), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_pool(rd_pool), .rd_addr(rd_addr), .rd_data(rd_data),
    .unit_live(unit_live), .bad_cmd(bad_cmd)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference state
  logic [15:0] mx [8][L];
  logic [15:0] my [8][L];
  logic [15:0] mz [64][L];
  bit m_live = 1'b0;
  bit m_bad  = 1'b0;
  int m_rem  = 0;

  function automatic bit lane_on(logic [6:0] m, int i);
    int n = int'(m[4:0]);
    case (m[6:5])
      2'd0:    return 1'b1;
      2'd1:    return i == n;
      2'd2:    return i < n;
      default: return i >= L - n;
    endcase
  endfunction

  function automatic logic [15:0] fmac(logic [15:0] z, logic [15:0] x, logic [15:0] y,
                                       logic [63:0] c);
    int a, b, p;
    logic [15:0] q, base;
    a = c[59] ? 1 : int'($signed(x));
    b = c[58] ? 1 : int'($signed(y));
    p = (a * b) >>> int'(c[56:53]);
    q = p[15:0];
    base = c[57] ? 16'd0 : z;
    return c[60] ? base - q : base + q;
  endfunction

  function automatic logic [63:0] mk(bit vec, logic [1:0] op, bit sub, bit xo, bit yo, bit zo,
                                     int sh, int xs, int ys, int zr,
                                     logic [6:0] xm, logic [6:0] ym);
    logic [63:0] c = '0;
    c[63] = vec; c[62:61] = op; c[60] = sub; c[59] = xo; c[58] = yo; c[57] = zo;
    c[56:53] = 4'(sh); c[52:50] = 3'(xs); c[49:47] = 3'(ys); c[46:41] = 6'(zr);
    c[40:34] = xm; c[33:27] = ym;
    return c;
  endfunction

  function automatic logic [RW-1:0] pat(int s);
    logic [RW-1:0] v;
    for (int i = 0; i < L; i++) begin
      v[i*W +: W] = 16'((s * 40503 + i * 9973 + i * i * 311) ^ (s << 11));
    end
    return v;
  endfunction

  // Reference model, advanced on each rising edge from the driven inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      m_live = 1'b0; m_bad = 1'b0; m_rem = 0;
    end else begin
      bit idle;
      idle  = (m_rem == 0);
      m_bad = 1'b0;
      if (m_rem > 0) m_rem--;
      if (cmd_valid && idle) begin
        case (cmd_word[62:61])
          2'd1: begin
            if (m_live) m_bad = 1'b1;
            else begin
              m_live = 1'b1;
              for (int r = 0; r < 64; r++)
                for (int i = 0; i < L; i++) begin
                  mz[r][i] = '0;
                  if (r < 8) begin mx[r][i] = '0; my[r][i] = '0; end
                end
            end
          end
          2'd2: m_live = 1'b0;
          2'd0: begin
            if (!m_live) m_bad = 1'b1;
            else begin
              int xs, ys;
              xs = int'(cmd_word[52:50]);
              ys = int'(cmd_word[49:47]);
              if (cmd_word[63]) begin
                int zr;
                zr = int'(cmd_word[46:41]);
                m_rem = 1;
                for (int i = 0; i < L; i++)
                  if (lane_on(cmd_word[40:34], i))
                    mz[zr][i] = fmac(mz[zr][i], mx[xs][i], my[ys][i], cmd_word);
              end else begin
                m_rem = L;
                for (int j = 0; j < L; j++)
                  for (int i = 0; i < L; i++)
                    if (lane_on(cmd_word[40:34], i) && lane_on(cmd_word[33:27], j))
                      mz[2*j][i] = fmac(mz[2*j][i], mx[xs][i], my[ys][j], cmd_word);
              end
            end
          end
          default: m_bad = 1'b1;
        endcase
      end else if (wr_valid && idle && !cmd_valid) begin
        if (!m_live) m_bad = 1'b1;
        else begin
          for (int i = 0; i < L; i++) begin
            case (wr_pool)
              2'd0: mx[wr_addr[2:0]][i] = wr_data[i*W +: W];
              2'd1: my[wr_addr[2:0]][i] = wr_data[i*W +: W];
              2'd2: mz[wr_addr][i]      = wr_data[i*W +: W];
              default: ;
            endcase
          end
        end
      end
    end
  end

  task automatic check(string req, logic [RW-1:0] act, logic [RW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Per-clock comparison of handshake and status pins (R1 R2 R3 R4 R5)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 R2 R4 R5 status", RW'({cmd_ready, wr_ready, unit_live, bad_cmd}),
            RW'({m_rem == 0, (m_rem == 0) && !cmd_valid, m_live, m_bad}));
    end
  end

  task automatic send(logic [63:0] c);
    @(negedge clk);
    cmd_word  = c;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] p, int a, logic [RW-1:0] d);
    @(negedge clk);
    wr_pool  = p;
    wr_addr  = 6'(a);
    wr_data  = d;
    wr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic cmp_all(string req);
    for (int p = 0; p < 3; p++) begin
      for (int r = 0; r < (p == 2 ? 64 : 8); r++) begin
        logic [RW-1:0] e;
        rd_pool = 2'(p);
        rd_addr = 6'(r);
        for (int i = 0; i < L; i++) begin
          if (!m_live)     e[i*W +: W] = '0;
          else if (p == 0) e[i*W +: W] = mx[r][i];
          else if (p == 1) e[i*W +: W] = my[r][i];
          else             e[i*W +: W] = mz[r][i];
        end
        #0.5;
        check(req, rd_data, e);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", RW'({cmd_ready, unit_live, bad_cmd}), RW'(3'b100));
    cmp_all("R1 reset readback");
    rst_n = 1'b1;
    @(negedge clk);

    // R2: refused while down
    send(mk(1'b0, 2'd0, 0, 0, 0, 0, 0, 1, 2, 0, 7'h00, 7'h00));
    wr(2'd0, 1, pat(1));
    cmp_all("R2 down");

    // R1: setup zeroes
    send(mk(1'b0, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 7'h00, 7'h00));
    cmp_all("R1 setup");

    // R3: loads
    for (int r = 0; r < 8; r++) begin
      wr(2'd0, r, pat(r + 10));
      wr(2'd1, r, pat(r + 30));
    end
    wr(2'd2, 3, pat(77));
    wr(2'd2, 4, pat(78));
    wr(2'd3, 5, pat(79));
    cmp_all("R3 writes");

    // R4: full matrix accumulate
    send(mk(1'b0, 2'd0, 0, 0, 0, 0, 0, 1, 2, 0, 7'h00, 7'h00));
    cmp_all("R4 matrix");

    // R6 R9 R10 R11: subtract, shift, first-n X lanes, last-n Y rows
    send(mk(1'b0, 2'd0, 1, 0, 0, 0, 3, 3, 5, 0, {2'd2, 5'd5}, {2'd3, 5'd4}));
    cmp_all("R6 R9 R10 R11 matrix masked");

    // R10: zero-count first-n mask leaves everything
    send(mk(1'b0, 2'd0, 0, 0, 0, 0, 0, 2, 2, 0, {2'd2, 5'd0}, 7'h00));
    cmp_all("R10 R11 empty mask");

    // R5 R10: vector, single lane 31 then all lanes
    send(mk(1'b1, 2'd0, 0, 0, 0, 0, 0, 3, 4, 7, {2'd1, 5'd31}, 7'h00));
    cmp_all("R5 R10 vector one lane");
    send(mk(1'b1, 2'd0, 0, 0, 0, 0, 15, 6, 7, 4, 7'h00, {2'd1, 5'd0}));
    cmp_all("R5 R9 vector shift");

    // R7: overwrite, plain and negated
    send(mk(1'b1, 2'd0, 1, 0, 0, 1, 2, 0, 1, 3, {2'd3, 5'd20}, 7'h00));
    cmp_all("R7 R6 overwrite negated");
    send(mk(1'b1, 2'd0, 0, 0, 0, 1, 0, 5, 5, 63, 7'h00, 7'h00));
    cmp_all("R7 overwrite");

    // R8: input disables
    send(mk(1'b0, 2'd0, 0, 1, 0, 0, 0, 4, 6, 0, 7'h00, {2'd2, 5'd3}));
    cmp_all("R8 x off");
    send(mk(1'b1, 2'd0, 0, 0, 1, 0, 1, 7, 0, 9, 7'h00, 7'h00));
    cmp_all("R8 y off");
    send(mk(1'b1, 2'd0, 1, 1, 1, 0, 0, 0, 0, 10, 7'h00, 7'h00));
    cmp_all("R8 both off");

    // R1: setup while up, reserved op
    send(mk(1'b0, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 7'h00, 7'h00));
    cmp_all("R1 resetup");
    send(mk(1'b0, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 7'h00, 7'h00));
    cmp_all("R1 reserved op");

    // R2: clear, then traffic refused
    send(mk(1'b0, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 7'h00, 7'h00));
    cmp_all("R2 cleared");
    send(mk(1'b1, 2'd0, 0, 0, 0, 0, 0, 1, 1, 1, 7'h00, 7'h00));
    wr(2'd2, 1, pat(5));
    send(mk(1'b0, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 7'h00, 7'h00));
    cmp_all("R2 R1 after clear");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule